// File: doc/BRIEF.md
# Write-Protected Bus Clock Divider

This block derives a slower peripheral bus clock from a fast input clock by integer division. Software programs a half-period count into a control register. Software must first unlock the register with a two-word key sequence before it can change the divisor. The new ratio never takes effect in the middle of a waveform. The block holds it as pending and loads it only when the output completes a full period. The output therefore never produces a runt pulse.

A ready flag is low for as long as a change is pending. Software polls it before it writes and again afterwards to learn when the new ratio is live. An enable bit gates the output. While the output is disabled, it is held low and any pending ratio is loaded at once. When software re-enables the output, it restarts from the beginning of a low phase.

Top module: `busdiv_top`

## Requirements
- R1: After reset, the divisor field is 0, the output is disabled and held low, ready is 1, and the control register reads 0x200.
- R2: With the output enabled and a divisor field F in effect, the output is high for exactly F+1 input cycles and then low for exactly F+1 input cycles.
- R3: Ready drops in the cycle after an accepted divisor write. It rises again only in the cycle in which the new ratio is loaded.
- R4: A pending ratio is loaded only at a falling edge of the output, so the period already in progress finishes with the old ratio.
- R5: The control register (address 0) reads the divisor field in bits [6:0], the enable bit in bit 8 and ready in bit 9. Once ready returns, the field reads back exactly the value that was written.
- R6: A divisor change is honoured only if an unlock came directly before it. An unlock is the key 0xC3A50F1E followed by the key 0x5A963CC3, written as consecutive writes to the key register (address 1). Every control write consumes the unlock. Without an unlock, the divisor field keeps its old value.
- R7: A control write made while a change is pending does not alter the pending value, even if the register is unlocked.
- R8: The enable bit (bit 8) is writable without an unlock. When it is cleared, the output goes low one cycle later and stays low. Any pending ratio is loaded at once. After the enable bit is set again, the output stays low for F+1 cycles before its first rise.
- R9: A key sequence that is broken by another key value, or that is written in the wrong order, does not unlock the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 control, 1 key) |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| bus_clk_o | output | 1 | Divided bus clock |
| ready_o | output | 1 | High when no divisor change is pending |

## Verification
The assertions check on every cycle the following behaviours:
- the ready drop after an accepted write
- the consumption of the unlock by every control write
- the stability of the stored divisor under locked or pending writes
- the low output while disabled
- the fact that a load with the output enabled coincides with a falling edge

Only the bench scenarios can show the exact high and low phase lengths for every one of the 128 field values. The same holds for the old period finishing intact after a mid-period write and for the restart timing after re-enable. The bench also covers the refusal of broken or reordered key sequences.

// File: rtl/busdiv_pkg.sv
package busdiv_pkg;
   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL = 2'd0,
      REG_KEY  = 2'd1
   } reg_addr_e;
endpackage

// File: rtl/busdiv_unlock.sv
module busdiv_unlock #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_KEYS = 2,
   parameter logic [NUM_KEYS*DATA_W-1:0] KEYS = '0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              key_wr_i,
   input  logic [DATA_W-1:0] key_data_i,
   input  logic              ctrl_wr_i,
   output logic              unlocked_o
);
   localparam int unsigned STG_W = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1;
   localparam logic [DATA_W-1:0] FIRST_KEY = KEYS[DATA_W-1:0];

   logic unlocked_q;
   assign unlocked_o = unlocked_q;

   generate
      if (NUM_KEYS == 1) begin : g_single
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               unlocked_q <= 1'b0;
            end else if (key_wr_i) begin
               unlocked_q <= (key_data_i == FIRST_KEY);
            end else if (ctrl_wr_i) begin
               unlocked_q <= 1'b0;
            end
         end
      end else begin : g_multi
         logic [STG_W-1:0]  stage_q;
         logic [DATA_W-1:0] exp_key;
         logic              last_stage;

         always_comb begin
            exp_key    = KEYS[DATA_W*int'(stage_q) +: DATA_W];
            last_stage = (int'(stage_q) == NUM_KEYS - 1);
         end

         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               unlocked_q <= 1'b0;
               stage_q    <= '0;
            end else if (key_wr_i) begin
               if (key_data_i == exp_key) begin
                  unlocked_q <= last_stage;
                  stage_q    <= last_stage ? '0 : stage_q + 1'b1;
               end else begin
                  unlocked_q <= 1'b0;
                  stage_q    <= (key_data_i == FIRST_KEY) ? STG_W'(1) : '0;
               end
            end else if (ctrl_wr_i) begin
               unlocked_q <= 1'b0;
               stage_q    <= '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/busdiv_regs.sv
module busdiv_regs
   import busdiv_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned DIV_W   = 7,
   parameter int unsigned EN_BIT  = 8,
   parameter int unsigned RDY_BIT = 9
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DIV_W-1:0]  div_data_i,
   input  logic              en_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic              unlocked_i,
   input  logic              apply_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [DIV_W-1:0]  target_o,
   output logic              pending_o,
   output logic              en_o,
   output logic              ctrl_wr_o,
   output logic              accept_o
);
   logic [DIV_W-1:0] target_q;
   logic             pending_q;
   logic             en_q;

   assign ctrl_wr_o = wr_en_i && (wr_addr_i == REG_CTRL);
   assign accept_o  = ctrl_wr_o && unlocked_i && !pending_q;
   assign target_o  = target_q;
   assign pending_o = pending_q;
   assign en_o      = en_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         target_q  <= '0;
         pending_q <= 1'b0;
         en_q      <= 1'b0;
      end else begin
         if (ctrl_wr_o) begin
            en_q <= en_data_i;
         end
         if (accept_o) begin
            target_q  <= div_data_i;
            pending_q <= 1'b1;
         end else if (apply_i) begin
            pending_q <= 1'b0;
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == REG_CTRL) begin
         rd_data_o[DIV_W-1:0] = target_q;
         rd_data_o[EN_BIT]    = en_q;
         rd_data_o[RDY_BIT]   = !pending_q;
      end
   end
endmodule

// File: rtl/busdiv_core.sv
module busdiv_core #(
   parameter int unsigned DIV_W = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             pending_i,
   input  logic [DIV_W-1:0] target_i,
   output logic             bus_clk_o,
   output logic             apply_o
);
   logic [DIV_W-1:0] active_q;
   logic [DIV_W-1:0] cnt_q;
   logic             out_q;
   logic             wrap;

   assign wrap      = (cnt_q == active_q);
   assign apply_o   = pending_i && (!en_i || (wrap && out_q));
   assign bus_clk_o = out_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         active_q <= '0;
         cnt_q    <= '0;
         out_q    <= 1'b0;
      end else begin
         if (apply_o) begin
            active_q <= target_i;
         end
         if (!en_i) begin
            cnt_q <= '0;
            out_q <= 1'b0;
         end else if (wrap) begin
            cnt_q <= '0;
            out_q <= !out_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/busdiv_top.sv
module busdiv_top
   import busdiv_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DIV_W    = 7,
   parameter int unsigned EN_BIT   = 8,
   parameter int unsigned RDY_BIT  = 9,
   parameter int unsigned NUM_KEYS = 2,
   parameter logic [NUM_KEYS*DATA_W-1:0] KEYS = {32'h5A96_3CC3, 32'hC3A5_0F1E}
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [1:0]        rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              bus_clk_o,
   output logic              ready_o
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("DIV_W must lie in 1..16");
      end
      if (EN_BIT < DIV_W || RDY_BIT < DIV_W || EN_BIT == RDY_BIT) begin : g_bad_bits
         $error("status bits overlap the divisor field");
      end
      if (EN_BIT >= DATA_W || RDY_BIT >= DATA_W) begin : g_bad_width
         $error("status bits outside the data word");
      end
      if (NUM_KEYS < 1) begin : g_bad_keys
         $error("NUM_KEYS must be at least 1");
      end
   endgenerate

   logic             unlocked;
   logic             ctrl_wr;
   logic             key_wr;
   logic             accept;
   logic             apply;
   logic             pending;
   logic             en_q;
   logic [DIV_W-1:0] target;

   assign key_wr  = wr_en_i && (wr_addr_i == REG_KEY);
   assign ready_o = !pending;

   busdiv_unlock #(
      .DATA_W  (DATA_W),
      .NUM_KEYS(NUM_KEYS),
      .KEYS    (KEYS)
   ) unlock_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .key_wr_i  (key_wr),
      .key_data_i(wr_data_i),
      .ctrl_wr_i (ctrl_wr),
      .unlocked_o(unlocked)
   );

   busdiv_regs #(
      .DATA_W (DATA_W),
      .DIV_W  (DIV_W),
      .EN_BIT (EN_BIT),
      .RDY_BIT(RDY_BIT)
   ) regs_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .div_data_i(wr_data_i[DIV_W-1:0]),
      .en_data_i (wr_data_i[EN_BIT]),
      .rd_addr_i (rd_addr_i),
      .unlocked_i(unlocked),
      .apply_i   (apply),
      .rd_data_o (rd_data_o),
      .target_o  (target),
      .pending_o (pending),
      .en_o      (en_q),
      .ctrl_wr_o (ctrl_wr),
      .accept_o  (accept)
   );

   busdiv_core #(
      .DIV_W(DIV_W)
   ) core_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_q),
      .pending_i(pending),
      .target_i (target),
      .bus_clk_o(bus_clk_o),
      .apply_o  (apply)
   );
endmodule

// File: rtl/busdiv_chk.sv
module busdiv_chk #(
   parameter int unsigned DIV_W = 7
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             ctrl_wr,
   input logic             unlocked,
   input logic             accept,
   input logic             apply,
   input logic             en_q,
   input logic [DIV_W-1:0] target,
   input logic             bus_clk_o,
   input logic             ready_o
);
   a_r3_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept |=> !ready_o);

   a_r3_ready_rise_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ready_o) |-> $past(apply));

   a_r4_load_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (apply && en_q) |=> $fell(bus_clk_o));

   a_r6_unlock_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_wr |=> !unlocked);

   a_r6_locked_keeps_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr && !unlocked) |=> $stable(target));

   a_r7_pending_keeps_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr && !ready_o) |=> $stable(target));

   a_r8_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_q |=> !bus_clk_o);
endmodule

bind busdiv_top busdiv_chk #(.DIV_W(DIV_W)) chk_i (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .ctrl_wr  (ctrl_wr),
   .unlocked (unlocked),
   .accept   (accept),
   .apply    (apply),
   .en_q     (en_q),
   .target   (target),
   .bus_clk_o(bus_clk_o),
   .ready_o  (ready_o)
);

// File: tb/busdiv_top_tb_top.sv
module busdiv_top_tb_top;
   localparam logic [31:0] KA = 32'hC3A5_0F1E;
   localparam logic [31:0] KB = 32'h5A96_3CC3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [1:0]  wr_addr;
   logic [31:0] wr_data;
   logic [1:0]  rd_addr;
   logic [31:0] rd_data;
   logic        bus_clk;
   logic        ready;

   int n_cmp = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   busdiv_top dut_i (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .wr_en_i  (wr_en),
      .wr_addr_i(wr_addr),
      .wr_data_i(wr_data),
      .rd_addr_i(rd_addr),
      .rd_data_o(rd_data),
      .bus_clk_o(bus_clk),
      .ready_o  (ready)
   );

   function automatic logic [31:0] mk(input int f, input bit en);
      return (32'(en) << 8) | 32'(f);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_addr = a;
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic unlock();
      wr(2'd1, KA);
      wr(2'd1, KB);
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic wait_ready();
      while (ready !== 1'b1) @(negedge clk);
   endtask

   task automatic measure(output int hi, output int lo);
      while (bus_clk !== 1'b0) @(negedge clk);
      while (bus_clk !== 1'b1) @(negedge clk);
      hi = 0;
      while (bus_clk === 1'b1) begin hi++; @(negedge clk); end
      lo = 0;
      while (bus_clk === 1'b0) begin lo++; @(negedge clk); end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      int hi, lo, rem, bad;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 ready", 32'(ready), 32'd1);
      check("R1 out", 32'(bus_clk), 32'd0);
      rd(2'd0, d);
      check("R1 ctrl", d, 32'h200);
      bad = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (bus_clk !== 1'b0) bad++;
      end
      check("R1 held low", 32'(bad), 32'd0);

      // R2 / R5 sweep over every field value
      for (int f = 0; f < 128; f++) begin
         unlock();
         wr(2'd0, mk(f, 1'b1));
         wait_ready();
         rd(2'd0, d);
         check("R5 readback", d, 32'(f) | 32'h300);
         measure(hi, lo);
         check("R2 high", 32'(hi), 32'(f + 1));
         check("R2 low", 32'(lo), 32'(f + 1));
      end

      // R4: change during a low phase, old period completes
      unlock();
      wr(2'd0, mk(3, 1'b1));
      wait_ready();
      measure(hi, lo);
      unlock();
      while (bus_clk !== 1'b1) @(negedge clk);
      while (bus_clk !== 1'b0) @(negedge clk);
      wr(2'd0, mk(9, 1'b1));
      check("R3 ready low after write", 32'(ready), 32'd0);
      rem = 0;
      while (bus_clk === 1'b0) begin rem++; @(negedge clk); end
      check("R4 old low finishes", 32'(rem), 32'd3);
      hi = 0; bad = 0;
      while (bus_clk === 1'b1) begin
         hi++;
         if (ready !== 1'b0) bad++;
         @(negedge clk);
      end
      check("R4 old high kept", 32'(hi), 32'd4);
      check("R3 ready low while pending", 32'(bad), 32'd0);
      check("R3 ready at load", 32'(ready), 32'd1);
      lo = 0;
      while (bus_clk === 1'b0) begin lo++; @(negedge clk); end
      check("R4 new low", 32'(lo), 32'd10);
      hi = 0;
      while (bus_clk === 1'b1) begin hi++; @(negedge clk); end
      check("R4 new high", 32'(hi), 32'd10);

      // R6: locked write ignored
      wr(2'd0, mk(20, 1'b1));
      check("R6 ready stays", 32'(ready), 32'd1);
      rd(2'd0, d);
      check("R6 locked keeps", d, 32'h309);

      // R9: broken and reordered key sequences
      wr(2'd1, KA); wr(2'd1, 32'h1234_5678); wr(2'd1, KB);
      wr(2'd0, mk(20, 1'b1));
      rd(2'd0, d);
      check("R9 broken sequence", d, 32'h309);
      wr(2'd1, KB); wr(2'd1, KA);
      wr(2'd0, mk(21, 1'b1));
      rd(2'd0, d);
      check("R9 reversed sequence", d, 32'h309);

      // R6: proper unlock, then one-shot consumption
      unlock();
      wr(2'd0, mk(20, 1'b1));
      check("R3 ready drops", 32'(ready), 32'd0);
      wait_ready();
      wr(2'd0, mk(30, 1'b1));
      rd(2'd0, d);
      check("R6 one-shot", d, 32'h300 | 32'd20);

      // R7: write while pending ignored
      unlock();
      wr(2'd0, mk(127, 1'b1));
      wait_ready();
      unlock();
      wr(2'd0, mk(50, 1'b1));
      unlock();
      wr(2'd0, mk(60, 1'b1));
      wait_ready();
      rd(2'd0, d);
      check("R7 pending kept", d, 32'h300 | 32'd50);
      measure(hi, lo);
      check("R7 ratio high", 32'(hi), 32'd51);
      check("R7 ratio low", 32'(lo), 32'd51);

      // R8: disable and re-enable
      wr(2'd0, mk(50, 1'b0));
      @(negedge clk);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         if (bus_clk !== 1'b0) bad++;
         @(negedge clk);
      end
      check("R8 disabled low", 32'(bad), 32'd0);
      rd(2'd0, d);
      check("R8 enable bit clear", d, 32'h200 | 32'd50);
      unlock();
      wr(2'd0, mk(4, 1'b0));
      check("R8 pending while off", 32'(ready), 32'd0);
      @(negedge clk);
      check("R8 immediate load", 32'(ready), 32'd1);
      wr(2'd0, mk(4, 1'b1));
      lo = 0;
      while (bus_clk === 1'b0) begin lo++; @(negedge clk); end
      check("R8 restart low", 32'(lo), 32'd5);
      hi = 0;
      while (bus_clk === 1'b1) begin hi++; @(negedge clk); end
      check("R8 restart high", 32'(hi), 32'd5);

      finish_run();
   end
endmodule